// File: doc/BRIEF.md
# Shadow Register Scan Chain

This block sits beside a small CPU inside an FPGA and lets an external serial host read and steer that CPU. It holds a chain of shadow registers that shifts one bit for each rising edge of a host scan clock. Data enters at one end from MOSI and leaves at the other end on MISO. On request, the chain takes a snapshot of the live CPU registers in one step: four 8-bit general registers, the program counter and the 16-bit instruction register. The host can then shift that snapshot out.

A falling edge of the CPU clock arms the snapshot. The next rising scan-clock edge then captures the CPU registers instead of shifting. The falling scan-clock edge that follows disarms the snapshot again. A typical host sequence is: pulse the CPU clock, give one extra scan-clock pulse to capture, then run a full 64-bit scan.

The most significant segment of the chain is a control byte, which is never overwritten by a capture. One of its bits makes the instruction decoder use the shadow instruction register. Another bit blocks the decoder's load enables so that the real instruction register is loaded from the shadow copy. Both scan-side clocks are oversampled by a fast local clock `clk`, so all storage runs in a single clock domain.

Top module: `shadow_scan_chain`

## Requirements
- R1: The chain holds 64 bits, and each rising scan-clock edge with no capture pending shifts it by one place. A 64-bit word scanned in most-significant-bit first therefore comes back out unchanged, most-significant-bit first, during the next 64-bit scan.
- R2: MOSI enters bit 0 of the chain, which is the least significant bit of the shadow instruction register. MISO is driven from bit 63, which is the most significant bit of the control byte. MISO does not change while the scan clock is low, and `shadow_ir` shows chain bits 15:0.
- R3: Bit 1 of the control byte (chain bit 57) drives `dec_use_shadow_ir` directly from the register's current contents.
- R4: Bit 2 of the control byte (chain bit 58) drives `dec_load_gate` directly from the register's current contents.
- R5: A falling edge of `cpu_clk` arms the capture. A rising edge of `cpu_clk` alone does not arm it.
- R6: While the capture is armed, the next rising scan-clock edge loads the whole chain at once, and the control byte keeps its value. The layout after the load is: bits 15:0 = IR, 23:16 = PC, 31:24 = R3, 39:32 = R2, 47:40 = R1, 55:48 = R0. General register k is read from `cpu_gpr[8k+7:8k]`.
- R7: The first falling scan-clock edge after the capture disarms it. The following rising edges shift again, and changes to the CPU register inputs after that point do not reach the chain.
- R8: If no `cpu_clk` falling edge has occurred, changes to the CPU register inputs have no effect on the chain.
- R9: An asynchronous active-low reset clears the chain, the control outputs, MISO and a pending capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_clk | input | 1 | Host scan clock, each level held at least 4 `clk` cycles |
| scan_mosi | input | 1 | Serial data from the host |
| scan_miso | output | 1 | Serial data to the host (chain bit 63) |
| cpu_clk | input | 1 | CPU clock; its falling edge arms a capture |
| cpu_ir | input | 16 | Live instruction register |
| cpu_pc | input | 8 | Live program counter |
| cpu_gpr | input | 32 | Live general registers, register k at bits 8k+7:8k |
| dec_use_shadow_ir | output | 1 | Decoder takes the shadow IR instead of the real IR |
| dec_load_gate | output | 1 | Decoder load enables blocked; real IR loads from the shadow |
| shadow_ir | output | 16 | Current shadow instruction register |

## Verification
The bench builds the block with its default parameters: 16-bit IR, 8-bit registers, four general registers and two synchronizer stages, which gives a 64-bit chain. Each scan-clock level is held for four local clock cycles, the shortest spacing the two-stage edge detection allows. At this size the bench can run dozens of complete 64-bit scans. The scanned words sweep all four combinations of the two control bits, and the CPU inputs change between scans. Capture rounds with changing CPU values check the arm, capture and disarm order at the ports, including a reset while a capture is armed.

// File: rtl/shscan_pkg.sv
package shscan_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_LOAD  = 2'd2
  } chain_act_e;

  function automatic int chain_bits(input int ir_w, input int reg_w, input int n_gpr);
    return ir_w + reg_w * (n_gpr + 2);
  endfunction

  // offset of general register k; higher-numbered registers sit nearer the MOSI end
  function automatic int gpr_offset(input int ir_w, input int reg_w, input int n_gpr, input int k);
    return ir_w + reg_w * (n_gpr - k);
  endfunction

endpackage

// File: rtl/shscan_edge.sv
module shscan_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [SYNC-1:0] sync_q;
  logic            last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], din};
      last_q <= sync_q[SYNC-1];
    end
  end

  assign rise = sync_q[SYNC-1] & ~last_q;
  assign fall = ~sync_q[SYNC-1] & last_q;

  // a rise is always followed by a non-rise cycle (R2: one action per edge)
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/shscan_arm.sv
module shscan_arm
  import shscan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_fall,
  input  logic       scan_rise,
  input  logic       scan_fall,
  output logic       armed,
  output chain_act_e act
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (cpu_fall)  armed_q <= 1'b1;
    else if (scan_fall) armed_q <= 1'b0;
  end

  assign armed = armed_q;

  always_comb begin
    act = ACT_HOLD;
    if (scan_rise) act = armed_q ? ACT_LOAD : ACT_SHIFT;
  end

  assert_arm_on_cpu_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fall |=> armed_q);

  assert_disarm_on_scan_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_fall && !cpu_fall) |=> !armed_q);

  assert_arm_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_fall && !scan_fall) |=> $stable(armed_q));

endmodule

// File: rtl/shscan_chain.sv
module shscan_chain
  import shscan_pkg::*;
#(
  parameter int IR_W     = 16,
  parameter int REG_W    = 8,
  parameter int NUM_GPR  = 4,
  parameter int SEL_BIT  = 1,
  parameter int GATE_BIT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  chain_act_e               act,
  input  logic                     mosi,
  input  logic [IR_W-1:0]          cpu_ir,
  input  logic [REG_W-1:0]         cpu_pc,
  input  logic [NUM_GPR*REG_W-1:0] cpu_gpr,
  output logic                     miso,
  output logic                     ctl_sel,
  output logic                     ctl_gate,
  output logic [IR_W-1:0]          sh_ir
);
  localparam int LEN     = chain_bits(IR_W, REG_W, NUM_GPR);
  localparam int CTRL_LO = LEN - REG_W;

  logic [LEN-1:0]     chain_q;
  logic [CTRL_LO-1:0] cap_w;

  assign cap_w[IR_W-1:0]          = cpu_ir;
  assign cap_w[IR_W +: REG_W]     = cpu_pc;

  for (genvar k = 0; k < NUM_GPR; k++) begin : g_gpr
    assign cap_w[gpr_offset(IR_W, REG_W, NUM_GPR, k) +: REG_W] = cpu_gpr[k*REG_W +: REG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      case (act)
        ACT_SHIFT: chain_q <= {chain_q[LEN-2:0], mosi};
        ACT_LOAD:  chain_q[CTRL_LO-1:0] <= cap_w;
        default:   chain_q <= chain_q;
      endcase
    end
  end

  assign miso     = chain_q[LEN-1];
  assign ctl_sel  = chain_q[CTRL_LO + SEL_BIT];
  assign ctl_gate = chain_q[CTRL_LO + GATE_BIT];
  assign sh_ir    = chain_q[IR_W-1:0];

  assert_hold_without_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_HOLD) |=> $stable(chain_q));

  assert_load_keeps_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOAD) |=> $stable(chain_q[LEN-1:CTRL_LO]));

  assert_load_takes_ir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOAD) |=> (sh_ir == $past(cpu_ir)));

  assert_shift_moves_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_SHIFT) |=> (miso == $past(chain_q[LEN-2])));

endmodule

// File: rtl/shadow_scan_chain.sv
module shadow_scan_chain
  import shscan_pkg::*;
#(
  parameter int IR_W    = 16,
  parameter int REG_W   = 8,
  parameter int NUM_GPR = 4,
  parameter int SYNC    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scan_clk,
  input  logic                     scan_mosi,
  output logic                     scan_miso,
  input  logic                     cpu_clk,
  input  logic [IR_W-1:0]          cpu_ir,
  input  logic [REG_W-1:0]         cpu_pc,
  input  logic [NUM_GPR*REG_W-1:0] cpu_gpr,
  output logic                     dec_use_shadow_ir,
  output logic                     dec_load_gate,
  output logic [IR_W-1:0]          shadow_ir
);
  logic       scan_rise, scan_fall, cpu_rise, cpu_fall, armed;
  chain_act_e act;

  shscan_edge #(.SYNC(SYNC)) u_scan_edge (
    .clk(clk), .rst_n(rst_n), .din(scan_clk), .rise(scan_rise), .fall(scan_fall));

  shscan_edge #(.SYNC(SYNC)) u_cpu_edge (
    .clk(clk), .rst_n(rst_n), .din(cpu_clk), .rise(cpu_rise), .fall(cpu_fall));

  shscan_arm u_arm (
    .clk(clk), .rst_n(rst_n), .cpu_fall(cpu_fall), .scan_rise(scan_rise),
    .scan_fall(scan_fall), .armed(armed), .act(act));

  shscan_chain #(
    .IR_W(IR_W), .REG_W(REG_W), .NUM_GPR(NUM_GPR), .SEL_BIT(1), .GATE_BIT(2)
  ) u_chain (
    .clk(clk), .rst_n(rst_n), .act(act), .mosi(scan_mosi),
    .cpu_ir(cpu_ir), .cpu_pc(cpu_pc), .cpu_gpr(cpu_gpr),
    .miso(scan_miso), .ctl_sel(dec_use_shadow_ir), .ctl_gate(dec_load_gate),
    .sh_ir(shadow_ir));

  // a CPU rising edge never arms a capture
  assert_rise_no_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rise && !armed) |=> !armed);

endmodule

// File: tb/sim_shadow_scan_chain.sv
`timescale 1ns/1ps
module sim_shadow_scan_chain;
  localparam int PH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_clk = 1'b0, scan_mosi = 1'b0, cpu_clk = 1'b0;
  logic [15:0] cpu_ir = '0;
  logic [7:0]  cpu_pc = '0;
  logic [31:0] cpu_gpr = '0;
  logic        scan_miso, dec_use_shadow_ir, dec_load_gate;
  logic [15:0] shadow_ir;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  shadow_scan_chain u0 (
    .clk(clk), .rst_n(rst_n), .scan_clk(scan_clk), .scan_mosi(scan_mosi),
    .scan_miso(scan_miso), .cpu_clk(cpu_clk), .cpu_ir(cpu_ir), .cpu_pc(cpu_pc),
    .cpu_gpr(cpu_gpr), .dec_use_shadow_ir(dec_use_shadow_ir),
    .dec_load_gate(dec_load_gate), .shadow_ir(shadow_ir));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan64(input logic [63:0] tx, output logic [63:0] rx);
    logic early;
    for (int i = 63; i >= 0; i--) begin
      scan_mosi = tx[i];
      tick(1);
      early = scan_miso;
      tick(PH - 1);
      rx[i] = scan_miso;
      if (early !== rx[i]) chk("R2 miso stable while scan clock low", {63'd0, rx[i]}, {63'd0, early});
      scan_clk = 1'b1;
      tick(PH);
      scan_clk = 1'b0;
    end
    tick(PH);
  endtask

  task automatic scan_pulse();
    scan_clk = 1'b1; tick(PH); scan_clk = 1'b0; tick(PH);
  endtask

  task automatic set_cpu(input int s);
    cpu_ir  = 16'(s * 16'h1357 + 16'h0A5C);
    cpu_pc  = 8'(s * 8'h1D + 8'h33);
    cpu_gpr = 32'(s * 32'h0B16_2C59 + 32'h8100_4E27);
  endtask

  function automatic logic [63:0] snap(input logic [7:0] ctrl);
    return {ctrl, cpu_gpr[7:0], cpu_gpr[15:8], cpu_gpr[23:16], cpu_gpr[31:24], cpu_pc, cpu_ir};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] prev, tx, rx, exp;
    set_cpu(1);
    tick(3);
    // R9: reset state
    chk("R9 reset miso", {63'd0, scan_miso}, 64'd0);
    chk("R9 reset ctrl outputs", {62'd0, dec_load_gate, dec_use_shadow_ir}, 64'd0);
    chk("R9 reset shadow ir", {48'd0, shadow_ir}, 64'd0);
    rst_n = 1'b1;
    tick(3);

    // R1 R2 R3 R4 R8: pattern sweep while CPU inputs wander
    prev = '0;
    for (int p = 0; p < 24; p++) begin
      tx = (64'h9E37_79B9_7F4A_7C15 * 64'(p + 1)) ^ 64'(p * 64'h0123_4567);
      tx[58:57] = 2'(p);
      set_cpu(p + 7);
      scan64(tx, rx);
      chk("R1 R8 scan out equals previous scan in", rx, prev);
      chk("R3 use shadow ir from control bit 1", {63'd0, dec_use_shadow_ir}, {63'd0, tx[57]});
      chk("R4 load gate from control bit 2", {63'd0, dec_load_gate}, {63'd0, tx[58]});
      chk("R2 shadow ir equals low chain bits", {48'd0, shadow_ir}, {48'd0, tx[15:0]});
      prev = tx;
    end

    // R5 R6 R7: capture rounds
    for (int c = 0; c < 6; c++) begin
      tx = ~(64'hC2B2_AE3D_27D4_EB4F * 64'(c + 3));
      set_cpu(40 + c);
      cpu_clk = 1'b1; tick(PH);
      scan64(tx, rx);
      chk("R5 cpu rising edge does not arm", rx, prev);
      prev = tx;
      cpu_clk = 1'b0; tick(PH);
      scan_pulse();
      exp = snap(prev[63:56]);
      set_cpu(90 + c);
      tx = 64'hF0E1_D2C3_B4A5_9687 ^ 64'(c * 64'h1111);
      scan64(tx, rx);
      chk("R6 R7 captured snapshot scanned out", rx, exp);
      prev = tx;
    end

    // R9: reset while armed and mid-state
    cpu_clk = 1'b1; tick(PH);
    cpu_clk = 1'b0; tick(PH);
    rst_n = 1'b0; tick(2);
    chk("R9 async reset clears miso", {63'd0, scan_miso}, 64'd0);
    chk("R9 async reset clears controls", {62'd0, dec_load_gate, dec_use_shadow_ir}, 64'd0);
    rst_n = 1'b1; tick(3);
    scan64(64'h0, rx);
    chk("R9 reset clears chain and pending capture", rx, 64'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule